// File: doc/BRIEF.md
# Sensor Start-Up and Identification Sequencer

This block takes an attached three-axis inertial sensor from power-up to a known, usable state. After the synchronous reset is released, it sends a software-reset command to the sensor. It then waits for a settling period measured in milliseconds and reads the identity register. From the value returned it decides which of two sensor variants is present. The second variant has angle outputs, and the block enables them with one extra register write. The block then reports completion, or reports failure.

The block has no serial logic of its own. It hands each register access to a separate frame engine over a request/response port. The frame engine builds the serial frame, computes the checksum, runs the transfer and returns the 16-bit data, the 2-bit return status and a transport-error flag. When the return status reports a device error, the block makes one recovery read of the status register. That read clears the error, and the block keeps its low nine bits as a diagnostic word. The sequence then goes on as if the original access had succeeded. A pulse on `start` while the block is finished runs the whole sequence again.

Top module: `sensor_boot_seq`

## Requirements
- R1: After reset or a restart, the first request is a write (`req_write`=1) of 0x0020 to register address 0x0D.
- R2: After the reset write completes, the identity read request appears exactly SETTLE_MS*CLK_HZ/1000 cycles after the response cycle of the last access before it. That last access is the reset write, or its recovery read.
- R3: An identity read (address 0x10) that returns 0x0051 ends the sequence with `done`=1 and `variant`=2'b01, and no further request is made.
- R4: An identity value of 0x00C1 sets `variant`=2'b10 and causes a write of 0x001F to address 0x0C. When that write completes, `done`=1. The write to 0x0C is never issued for any other identity.
- R5: Any other identity value ends the sequence with `fail`=1 and `variant`=2'b00.
- R6: A response with `rsp_status`=2'b11 (device error) and no transport error is followed by a read of address 0x06. If that read again reports status 2'b11, `status_word` takes bits [8:0] of its data. The sequence then continues from the step after the original access, using the original access's data.
- R7: If the recovery read returns a status other than 2'b11, or returns a transport error, the sequence ends with `fail`=1.
- R8: A response with `rsp_xfer_err`=1 on any access ends the sequence with `fail`=1.
- R9: While `req_valid`=1 and `req_ready`=0, the request fields `req_write`, `req_addr` and `req_wdata` hold still and `req_valid` stays high.
- R10: A `start` pulse while `done` or `fail` is high clears `variant` and `status_word` and reruns from R1. A `start` pulse in any other state is ignored.
- R11: `done` and `fail` are never high together, and while either is high no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Rerun request, taken only when finished |
| req_valid | output | 1 | Register access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 5 | Sensor register address |
| req_wdata | output | 16 | Write data |
| req_ready | input | 1 | Frame engine accepts the request |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_rdata | input | 16 | Returned data |
| rsp_status | input | 2 | Sensor return status, 2'b11 = device error |
| rsp_xfer_err | input | 1 | Transport or checksum failure |
| done | output | 1 | Sequence finished successfully |
| fail | output | 1 | Sequence aborted |
| variant | output | 2 | 00 none, 01 first variant, 10 second variant |
| status_word | output | 9 | Status captured by the last recovery read |

## Verification
A wrong state register shows up at the request port within one access. The next request then carries the wrong address or direction, or arrives at the wrong time: early or late identity reads show as a settle gap that differs from the parameterised count. A faulty error path skips or repeats the read of address 0x06. It can also leave `status_word` unequal to the injected data, or pick a variant from the recovery data instead of the identity data. These errors are visible on the response that follows. A bad decode or a bad end state shows on `done`, `fail` and `variant` in the cycle after the final response.

// File: rtl/sbs_pkg.sv
// Shared types and constants of the start-up sequencer.
// Assumes a 5-bit register address and 16-bit register data.
package sbs_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int STAT_W = 9;

    typedef enum logic [3:0] {
        S_BOOT, S_RST_REQ, S_RST_RSP, S_WAIT, S_ID_REQ, S_ID_RSP,
        S_ANG_REQ, S_ANG_RSP, S_REC_REQ, S_REC_RSP, S_DONE, S_FAIL
    } seq_state_t;

    typedef enum logic [1:0] { PH_RST, PH_ID, PH_ANG } phase_t;

    localparam logic [1:0] VAR_NONE = 2'b00;
    localparam logic [1:0] VAR_A    = 2'b01;
    localparam logic [1:0] VAR_B    = 2'b10;

    localparam logic [1:0]        RS_DEV_ERR = 2'b11;
    localparam logic [ADDR_W-1:0] A_MODE     = 5'h0D;
    localparam logic [ADDR_W-1:0] A_IDENT    = 5'h10;
    localparam logic [ADDR_W-1:0] A_ANGLE    = 5'h0C;
    localparam logic [ADDR_W-1:0] A_STATUS   = 5'h06;
    localparam logic [DATA_W-1:0] V_SWRESET  = 16'h0020;
    localparam logic [DATA_W-1:0] V_ANGLE_ON = 16'h001F;
    localparam logic [DATA_W-1:0] ID_VAR_A   = 16'h0051;
    localparam logic [DATA_W-1:0] ID_VAR_B   = 16'h00C1;
endpackage

// File: rtl/sbs_settle_timer.sv
// Down-counter for the settle wait. A load sets it to CYCLES-1, and it
// then counts down to zero and holds there. Assumes CYCLES >= 1.
module sbs_settle_timer #(
    parameter int CYCLES = 26000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R2
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sbs_id_match.sv
// Compares an identity word with the two known variant codes.
// Purely combinational. At most one of the outputs is high.
module sbs_id_match
    import sbs_pkg::*;
(
    input  logic [DATA_W-1:0] id_word,
    output logic              is_a,
    output logic              is_b
);
    // Full-width compare against each known code.
    always_comb begin
        is_a = (id_word == ID_VAR_A);
        is_b = (id_word == ID_VAR_B);
    end
endmodule

// File: rtl/sensor_boot_seq.sv
// Start-up and identification sequencer for the attached sensor.
// Assumes the frame engine takes a request when valid and ready are both
// high, and answers each accepted request with one rsp_valid pulse,
// no earlier than the cycle after acceptance.
module sensor_boot_seq
    import sbs_pkg::*;
#(
    parameter int CLK_HZ    = 1_000_000,
    parameter int SETTLE_MS = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    input  logic [1:0]        rsp_status,
    input  logic              rsp_xfer_err,
    output logic              done,
    output logic              fail,
    output logic [1:0]        variant,
    output logic [STAT_W-1:0] status_word
);
    localparam int SETTLE_CYC = (CLK_HZ / 1000) * SETTLE_MS;

    seq_state_t        state_q, state_d;
    phase_t            ph_q, ph_d, adv_ph;
    logic [DATA_W-1:0] save_q, save_d, adv_data;
    logic [1:0]        var_q, var_d;
    logic [STAT_W-1:0] stat_q, stat_d;
    logic              adv_go, is_a, is_b, tmr_zero, tmr_load;

    sbs_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .zero(tmr_zero)
    );

    sbs_id_match u_match (.id_word(adv_data), .is_a(is_a), .is_b(is_b));

    // Drive the request fields from the current state.
    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        case (state_q)
            S_RST_REQ: begin req_valid = 1'b1; req_write = 1'b1;
                             req_addr = A_MODE; req_wdata = V_SWRESET; end
            S_ID_REQ:  begin req_valid = 1'b1; req_addr = A_IDENT; end
            S_ANG_REQ: begin req_valid = 1'b1; req_write = 1'b1;
                             req_addr = A_ANGLE; req_wdata = V_ANGLE_ON; end
            S_REC_REQ: begin req_valid = 1'b1; req_addr = A_STATUS; end
            default:   ;
        endcase
    end

    // Pick the step to advance from and its data (direct or after recovery).
    always_comb begin
        adv_go   = 1'b0;
        adv_data = rsp_rdata;
        adv_ph   = PH_RST;
        case (state_q)
            S_RST_RSP: adv_ph = PH_RST;
            S_ID_RSP:  adv_ph = PH_ID;
            S_ANG_RSP: adv_ph = PH_ANG;
            S_REC_RSP: begin adv_ph = ph_q; adv_data = save_q; end
            default:   ;
        endcase
        if (rsp_valid && !rsp_xfer_err) begin
            case (state_q)
                S_RST_RSP, S_ID_RSP, S_ANG_RSP: adv_go = (rsp_status != RS_DEV_ERR);
                S_REC_RSP:                      adv_go = (rsp_status == RS_DEV_ERR);
                default:                        ;
            endcase
        end
    end

    // Next-state, saved context and result registers.
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        save_d  = save_q;
        var_d   = var_q;
        stat_d  = stat_q;
        case (state_q)
            S_BOOT:    state_d = S_RST_REQ;
            S_RST_REQ: if (req_ready) state_d = S_RST_RSP;
            S_ID_REQ:  if (req_ready) state_d = S_ID_RSP;
            S_ANG_REQ: if (req_ready) state_d = S_ANG_RSP;
            S_REC_REQ: if (req_ready) state_d = S_REC_RSP;
            S_WAIT:    if (tmr_zero) state_d = S_ID_REQ;
            S_RST_RSP, S_ID_RSP, S_ANG_RSP: begin
                if (rsp_valid && (rsp_xfer_err || rsp_status == RS_DEV_ERR)) begin
                    state_d = rsp_xfer_err ? S_FAIL : S_REC_REQ;
                    ph_d    = adv_ph;
                    save_d  = rsp_rdata;
                end
            end
            S_REC_RSP: begin
                if (rsp_valid && !adv_go) state_d = S_FAIL;
                if (adv_go) stat_d = rsp_rdata[STAT_W-1:0];
            end
            S_DONE, S_FAIL: begin
                if (start) begin
                    state_d = S_RST_REQ;
                    var_d   = VAR_NONE;
                    stat_d  = '0;
                end
            end
            default: state_d = S_FAIL;
        endcase
        if (adv_go) begin
            case (adv_ph)
                PH_RST: state_d = S_WAIT;
                PH_ID: begin
                    state_d = is_a ? S_DONE : (is_b ? S_ANG_REQ : S_FAIL);
                    var_d   = is_a ? VAR_A  : (is_b ? VAR_B : VAR_NONE);
                end
                default: state_d = S_DONE;
            endcase
        end
    end

    assign tmr_load = (state_d == S_WAIT) && (state_q != S_WAIT);

    // State and context registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_BOOT;
            ph_q    <= PH_RST;
            save_q  <= '0;
            var_q   <= VAR_NONE;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            save_q  <= save_d;
            var_q   <= var_d;
            stat_q  <= stat_d;
        end
    end

    assign done        = (state_q == S_DONE);
    assign fail        = (state_q == S_FAIL);
    assign variant     = var_q;
    assign status_word = stat_q;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_write) && $stable(req_wdata)));

    // R11
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R11
    end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !req_valid);

    // R4
    angle_only_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == A_ANGLE) |-> (variant == VAR_B));

    // R3
    done_has_var_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (variant != VAR_NONE));

    // R8
    xfer_err_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_xfer_err && !req_valid && !done && !fail
         && state_q != S_WAIT && state_q != S_BOOT) |=> fail);
endmodule

// File: tb/sensor_boot_seq_bench.sv
module sensor_boot_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 20_000;
    localparam int SETTLE_MS  = 26;
    localparam int N_SETTLE   = (CLK_HZ / 1000) * SETTLE_MS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_valid, req_write;
    logic [4:0]  req_addr;
    logic [15:0] req_wdata;
    logic        req_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_rdata = '0;
    logic [1:0]  rsp_status = '0;
    logic        rsp_xfer_err = 1'b0;
    logic        done, fail;
    logic [1:0]  variant;
    logic [8:0]  status_word;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int req_seen_cyc = 0;
    int rsp_done_cyc = 0;

    sensor_boot_seq #(.CLK_HZ(CLK_HZ), .SETTLE_MS(SETTLE_MS)) u_sensor_boot_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_status(rsp_status), .rsp_xfer_err(rsp_xfer_err),
        .done(done), .fail(fail), .variant(variant), .status_word(status_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    function automatic logic [1:0] exp_variant(input logic [15:0] id);
        if (id == 16'h0051) return 2'b01;
        if (id == 16'h00C1) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [1:0] ok_status();
        return 2'($urandom_range(0, 2));
    endfunction

    // Acts as the frame engine for one access; checks the request (R1, R9).
    task automatic serve(input bit w, input logic [4:0] a, input logic [15:0] d,
                         input logic [15:0] rd, input logic [1:0] st,
                         input bit xe, input string tag);
        int hold;
        while (!req_valid) @(negedge clk);
        req_seen_cyc = cyc;
        check(req_write == w && req_addr == a, {tag, " dir/addr"},
              {req_write, req_addr}, {w, a});
        if (w) check(req_wdata == d, {tag, " wdata"}, req_wdata, d);
        hold = $urandom_range(0, 2);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(req_valid && req_addr == a && req_write == w, "R9 hold",
                  {req_valid, req_addr}, {1'b1, a});
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rsp_valid = 1'b1; rsp_rdata = rd; rsp_status = st; rsp_xfer_err = xe;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_xfer_err = 1'b0;
        rsp_done_cyc = cyc;
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Full run; err_at picks the access given a device error (-1 none, 0 reset, 1 id, 2 angle).
    task automatic do_run(input logic [15:0] id, input int err_at, input logic [15:0] srd);
        logic [1:0] ev;
        int t0;
        bit used_err = 1'b0;
        ev = exp_variant(id);
        serve(1'b1, 5'h0D, 16'h0020, 16'h0000, err_at == 0 ? 2'b11 : ok_status(), 1'b0, "R1 reset write");
        if (err_at == 0) begin
            serve(1'b0, 5'h06, 16'h0, srd, 2'b11, 1'b0, "R6 recovery read");
            used_err = 1'b1;
            check(status_word == srd[8:0], "R6 status capture", status_word, srd[8:0]);
        end
        t0 = rsp_done_cyc;
        serve(1'b0, 5'h10, 16'h0, id, err_at == 1 ? 2'b11 : ok_status(), 1'b0, "R2 id read");
        check(req_seen_cyc - t0 == N_SETTLE, "R2 settle gap", req_seen_cyc - t0, N_SETTLE);
        if (err_at == 1) begin
            serve(1'b0, 5'h06, 16'h0, srd, 2'b11, 1'b0, "R6 recovery read");
            used_err = 1'b1;
        end
        if (ev == 2'b10) begin
            serve(1'b1, 5'h0C, 16'h001F, 16'h0, err_at == 2 ? 2'b11 : ok_status(), 1'b0, "R4 angle write");
            if (err_at == 2) begin
                serve(1'b0, 5'h06, 16'h0, srd, 2'b11, 1'b0, "R6 recovery read");
                used_err = 1'b1;
            end
        end
        if (ev == 2'b00) begin
            check(fail && !done, "R5 fail on unknown id", {done, fail}, 2'b01);
        end else begin
            check(done && !fail, "R3 done", {done, fail}, 2'b10);
        end
        check(variant == ev, "R3/R4/R5 variant", variant, ev);
        check(status_word == (used_err ? srd[8:0] : 9'h0), "R6 status word",
              status_word, used_err ? srd[8:0] : 9'h0);
        repeat (3) begin
            @(negedge clk);
            check(!req_valid && !(done && fail), "R11 quiet end", req_valid, 0);
        end
    endtask

    initial begin
        logic [15:0] rid, srd;
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        check(!req_valid && !done && !fail && variant == 2'b00 && status_word == 9'h0,
              "reset state", {req_valid, done, fail}, 0);
        rst_n = 1'b1;

        // R3: first variant, no errors
        do_run(16'h0051, -1, 16'h0);
        // R4: second variant with angle enable
        kick(); do_run(16'h00C1, -1, 16'h0);
        // R5: unknown identity
        kick(); do_run(16'h0052, -1, 16'h0);
        // R6: device error on the reset write
        kick(); do_run(16'h0051, 0, 16'h01A5);
        // R6: device error on the id read; decode uses the original data
        kick(); do_run(16'h00C1, 1, 16'h0F3C);
        // R6: device error on the angle write
        kick(); do_run(16'h00C1, 2, 16'h0101);

        // R7: recovery read reports no error -> fail
        kick();
        check(status_word == 9'h0 && variant == 2'b00, "R10 restart clears", status_word, 0);
        serve(1'b1, 5'h0D, 16'h0020, 16'h0, 2'b11, 1'b0, "R1 reset write");
        serve(1'b0, 5'h06, 16'h0, 16'h0033, 2'b00, 1'b0, "R7 recovery read");
        check(fail && !done, "R7 recovery without error fails", {done, fail}, 2'b01);

        // R7: transport error on recovery read -> fail
        kick();
        serve(1'b1, 5'h0D, 16'h0020, 16'h0, 2'b11, 1'b0, "R1 reset write");
        serve(1'b0, 5'h06, 16'h0, 16'h0033, 2'b11, 1'b1, "R7 recovery read");
        check(fail && !done, "R7 transport error on recovery fails", {done, fail}, 2'b01);

        // R8: transport error on the angle write
        kick();
        serve(1'b1, 5'h0D, 16'h0020, 16'h0, 2'b00, 1'b0, "R1 reset write");
        serve(1'b0, 5'h10, 16'h0, 16'h00C1, 2'b01, 1'b0, "R4 id read");
        serve(1'b1, 5'h0C, 16'h001F, 16'h0, 2'b00, 1'b1, "R8 angle write");
        check(fail && !done, "R8 transport error fails", {done, fail}, 2'b01);

        // R10: start while busy is ignored
        kick();
        serve(1'b1, 5'h0D, 16'h0020, 16'h0, 2'b00, 1'b0, "R1 reset write");
        kick();
        serve(1'b0, 5'h10, 16'h0, 16'h0051, 2'b00, 1'b0, "R10 busy start ignored");
        check(done && variant == 2'b01, "R10 run completes", {done, variant}, 3'b101);

        // Random runs
        for (int k = 0; k < 8; k++) begin
            case ($urandom_range(0, 2))
                0: rid = 16'h0051;
                1: rid = 16'h00C1;
                default: begin
                    rid = 16'($urandom);
                    if (rid == 16'h0051 || rid == 16'h00C1) rid = 16'h1234;
                end
            endcase
            srd = 16'($urandom);
            kick();
            do_run(rid, $urandom_range(0, 3) - 1, srd);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule